// File: doc/BRIEF.md
# Two-Half Sparse-Carry Adder with Packed Lanes

This block is a 64-bit integer adder/subtractor paired with a small logic unit, built for an execution stage. The width is cut into two 32-bit halves. Inside each half, a radix-2 prefix network works on 4-bit groups, so it yields a carry only at each nibble boundary. Every nibble computes its sum twice, once for carry-in 0 and once for carry-in 1, and the boundary carry then picks one of the two.

The lower half finishes in the cycle after the operands are captured. Its carry-out goes into a register, and the upper half uses it one cycle later. As a result, the upper 32 bits of a result and the carry out appear one clock after the lower 32 bits.

When a result is registered, a 2:1 choice takes either the adder sum or the logic-unit result. A lane mode forces carries to stop at 8-bit or 16-bit boundaries, so one operation performs several independent packed additions or subtractions. Subtraction is A + ~B + 1, with the +1 entering at the bottom of every active lane.

Top module: `split_prefix_alu`

## Requirements
- R1: While rst_n is low, and after it is released until the first operation result arrives, result and carry_out are zero.
- R2: With use_logic=0, op_sub=0 and lane_mode 00, the result is the 64-bit sum of op_a and op_b. carry_out is the carry out of bit 63.
- R3: With op_sub=1, each lane computes A + ~B + 1. carry_out is 1 exactly when the top lane has no borrow.
- R4: An operation captured at clock edge k shows its bits 31:0 on result after edge k+1. Its bits 63:32 and its carry_out appear after edge k+2. A new operation may be issued on every edge.
- R5: lane_mode 01 forms four independent 16-bit lanes. No carry crosses bits 16, 32 or 48. carry_out is the carry out of the lane at bits 63:48.
- R6: lane_mode 10 forms eight independent 8-bit lanes. No carry crosses any multiple of 8 bits. carry_out is the carry out of the lane at bits 63:56.
- R7: lane_mode 11 behaves exactly like lane_mode 00 (full width).
- R8: With use_logic=1, the result is selected by logic_op: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives A AND B. op_sub and lane_mode have no effect, and carry_out is 0.
- R9: A carry generated at bit 0 ripples correctly through every nibble and across the half boundary. For example, all-ones plus one gives zero with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sub | input | 1 | 1 selects subtract |
| lane_mode | input | 2 | 00/11 full width, 01 16-bit lanes, 10 8-bit lanes |
| use_logic | input | 1 | 1 selects the logic-unit result |
| logic_op | input | 2 | Logic function: 00 AND, 01 OR, 10 XOR, 11 AND |
| result | output | 64 | Lower half of newest op, upper half of the op before it |
| carry_out | output | 1 | Carry of the top lane, aligned with result[63:32] |

## Verification
The block holds only pipeline registers, so any corrupted internal state is visible at the ports within two or three edges.

A wrong bridge carry or a wrong upper-stage operand shows up only in result[63:32] and carry_out, one edge after the matching lower half looked correct. A wrong lane kill or a missing subtract injection flips the first bit above the affected lane boundary in the very next registered half.

The stimulus stream therefore issues one operation per edge. Each half is compared against its own operation, which exposes both skew errors and cross-lane leakage.

// File: rtl/spt_alu_pkg.sv
package spt_alu_pkg;

    typedef enum logic [1:0] {
        LANE_FULL     = 2'b00,
        LANE_MID      = 2'b01,
        LANE_NARROW   = 2'b10,
        LANE_FULL_ALT = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        LOP_AND     = 2'b00,
        LOP_OR      = 2'b01,
        LOP_XOR     = 2'b10,
        LOP_AND_ALT = 2'b11
    } logic_op_e;

endpackage

// File: rtl/cond_nibble_sum.sv
module cond_nibble_sum #(
    parameter int NB = 4
) (
    input  logic [NB-1:0] a_i,
    input  logic [NB-1:0] b_i,
    output logic [NB-1:0] sum0_o,
    output logic [NB-1:0] sum1_o,
    output logic          grp_g_o,
    output logic          grp_p_o
);
    logic [NB:0] s0;
    logic [NB:0] s1;

    always_comb begin
        s0      = {1'b0, a_i} + {1'b0, b_i};
        s1      = {1'b0, a_i} + {1'b0, b_i} + {{NB{1'b0}}, 1'b1};
        sum0_o  = s0[NB-1:0];
        sum1_o  = s1[NB-1:0];
        grp_g_o = s0[NB];
        grp_p_o = &(a_i ^ b_i);
    end
endmodule

// File: rtl/sparse_carry_tree.sv
module sparse_carry_tree #(
    parameter int NG = 8
) (
    input  logic [NG-1:0] g_i,
    input  logic [NG-1:0] p_i,
    input  logic [NG-1:0] kill_i,
    input  logic          inj_i,
    input  logic          cin_i,
    output logic [NG-1:0] carry_o,
    output logic          cout_o
);
    localparam int LV = $clog2(NG);

    logic [NG-1:0] gt [0:LV];
    logic [NG-1:0] pt [0:LV];

    always_comb begin
        for (int j = 0; j < NG; j++) begin
            gt[0][j] = kill_i[j] ? inj_i : g_i[j];
            pt[0][j] = kill_i[j] ? 1'b0  : p_i[j];
        end
        for (int l = 0; l < LV; l++) begin
            for (int j = 0; j < NG; j++) begin
                if (j >= (1 << l)) begin
                    gt[l+1][j] = gt[l][j] | (pt[l][j] & gt[l][j-(1<<l)]);
                    pt[l+1][j] = pt[l][j] & pt[l][j-(1<<l)];
                end else begin
                    gt[l+1][j] = gt[l][j];
                    pt[l+1][j] = pt[l][j];
                end
            end
        end
    end

    always_comb begin
        carry_o[0] = cin_i;
        for (int j = 1; j < NG; j++) begin
            carry_o[j] = gt[LV][j-1] | (pt[LV][j-1] & cin_i);
        end
        cout_o = gt[LV][NG-1] | (pt[LV][NG-1] & cin_i);
    end
endmodule

// File: rtl/prefix_half_adder.sv
module prefix_half_adder #(
    parameter int HW = 32,
    parameter int NB = 4,
    parameter int NG = HW / NB
) (
    input  logic [HW-1:0] a_i,
    input  logic [HW-1:0] b_i,
    input  logic          cin_i,
    input  logic          inj_i,
    input  logic [NG-1:0] kill_i,
    output logic [HW-1:0] sum_o,
    output logic [NG-1:0] carry_o,
    output logic          cout_o
);
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [HW-1:0] sum0;
    logic [HW-1:0] sum1;

    for (genvar n = 0; n < NG; n++) begin : g_nib
        cond_nibble_sum #(.NB(NB)) u_nib (
            .a_i    (a_i[n*NB +: NB]),
            .b_i    (b_i[n*NB +: NB]),
            .sum0_o (sum0[n*NB +: NB]),
            .sum1_o (sum1[n*NB +: NB]),
            .grp_g_o(grp_g[n]),
            .grp_p_o(grp_p[n])
        );
        assign sum_o[n*NB +: NB] = carry_o[n] ? sum1[n*NB +: NB] : sum0[n*NB +: NB];
    end

    sparse_carry_tree #(.NG(NG)) u_tree (
        .g_i    (grp_g),
        .p_i    (grp_p),
        .kill_i (kill_i),
        .inj_i  (inj_i),
        .cin_i  (cin_i),
        .carry_o(carry_o),
        .cout_o (cout_o)
    );
endmodule

// File: rtl/split_prefix_alu.sv
module split_prefix_alu
    import spt_alu_pkg::*;
#(
    parameter int W          = 64,
    parameter int NB         = 4,
    parameter int LANE_SMALL = 8,
    parameter int LANE_WIDE  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic          op_sub,
    input  logic [1:0]    lane_mode,
    input  logic          use_logic,
    input  logic [1:0]    logic_op,
    output logic [W-1:0]  result,
    output logic          carry_out
);
    localparam int HW       = W / 2;
    localparam int NG       = HW / NB;
    localparam int NIB_WIDE = LANE_WIDE / NB;
    localparam int NIB_SML  = LANE_SMALL / NB;

    function automatic logic [NG-1:0] lane_kill(input int lane_bits);
        logic [NG-1:0] m;
        m = '0;
        for (int j = 0; j < NG - 1; j++) begin
            if ((((j + 1) * NB) % lane_bits) == 0) m[j] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NG-1:0] KILL_SML  = lane_kill(LANE_SMALL);
    localparam logic [NG-1:0] KILL_WIDE = lane_kill(LANE_WIDE);

    function automatic logic [NG-1:0] kill_for(input lane_mode_e m);
        logic [NG-1:0] k;
        unique case (m)
            LANE_MID:    k = KILL_WIDE;
            LANE_NARROW: k = KILL_SML;
            default:     k = '0;
        endcase
        return k;
    endfunction

    function automatic logic [HW-1:0] logic_unit(input logic [HW-1:0] x,
                                                 input logic [HW-1:0] y,
                                                 input logic_op_e     op);
        logic [HW-1:0] r;
        unique case (op)
            LOP_OR:  r = x | y;
            LOP_XOR: r = x ^ y;
            default: r = x & y;
        endcase
        return r;
    endfunction

    // stage 1: captured operation
    logic [W-1:0]  a1, b1;
    logic          sub1, lg1;
    lane_mode_e    mode1;
    logic_op_e     lop1;

    // stage 2: upper-half operation plus bridge carry
    logic [HW-1:0] a2, b2;
    logic          sub2, lg2, bridge_q;
    lane_mode_e    mode2;
    logic_op_e     lop2;

    logic [HW-1:0] res_lo_q, res_hi_q;
    logic          cout_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1    <= '0;
            b1    <= '0;
            sub1  <= 1'b0;
            lg1   <= 1'b0;
            mode1 <= LANE_FULL;
            lop1  <= LOP_AND;
        end else begin
            a1    <= op_a;
            b1    <= op_b;
            sub1  <= op_sub;
            lg1   <= use_logic;
            mode1 <= lane_mode_e'(lane_mode);
            lop1  <= logic_op_e'(logic_op);
        end
    end

    logic [HW-1:0] lo_b_eff, lo_sum;
    logic [NG-1:0] lo_carry;
    logic          lo_cout;

    assign lo_b_eff = sub1 ? ~b1[HW-1:0] : b1[HW-1:0];

    prefix_half_adder #(.HW(HW), .NB(NB), .NG(NG)) u_lo (
        .a_i    (a1[HW-1:0]),
        .b_i    (lo_b_eff),
        .cin_i  (sub1),
        .inj_i  (sub1),
        .kill_i (kill_for(mode1)),
        .sum_o  (lo_sum),
        .carry_o(lo_carry),
        .cout_o (lo_cout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo_q <= '0;
            bridge_q <= 1'b0;
            a2       <= '0;
            b2       <= '0;
            sub2     <= 1'b0;
            lg2      <= 1'b0;
            mode2    <= LANE_FULL;
            lop2     <= LOP_AND;
        end else begin
            res_lo_q <= lg1 ? logic_unit(a1[HW-1:0], b1[HW-1:0], lop1) : lo_sum;
            bridge_q <= lo_cout;
            a2       <= a1[W-1:HW];
            b2       <= b1[W-1:HW];
            sub2     <= sub1;
            lg2      <= lg1;
            mode2    <= mode1;
            lop2     <= lop1;
        end
    end

    logic [HW-1:0] hi_b_eff, hi_sum;
    logic [NG-1:0] hi_carry;
    logic          hi_cout, hi_cin;

    assign hi_b_eff = sub2 ? ~b2 : b2;
    assign hi_cin   = (mode2 == LANE_FULL || mode2 == LANE_FULL_ALT) ? bridge_q : sub2;

    prefix_half_adder #(.HW(HW), .NB(NB), .NG(NG)) u_hi (
        .a_i    (a2),
        .b_i    (hi_b_eff),
        .cin_i  (hi_cin),
        .inj_i  (sub2),
        .kill_i (kill_for(mode2)),
        .sum_o  (hi_sum),
        .carry_o(hi_carry),
        .cout_o (hi_cout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi_q <= '0;
            cout_q   <= 1'b0;
        end else begin
            res_hi_q <= lg2 ? logic_unit(a2, b2, lop2) : hi_sum;
            cout_q   <= lg2 ? 1'b0 : hi_cout;
        end
    end

    assign result    = {res_hi_q, res_lo_q};
    assign carry_out = cout_q;

    // R2
    add_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lg1 && !sub1 && b1[HW-1:0] == '0) |=> (res_lo_q == $past(a1[HW-1:0])));

    // R3
    sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lg1 && sub1 && a1[HW-1:0] == b1[HW-1:0]) |=> (res_lo_q == '0 && bridge_q));

    // R5
    wide_lane_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == LANE_MID) |-> (lo_carry[NIB_WIDE] == sub1 && hi_carry[0] == sub2 || mode2 != LANE_MID));

    // R6
    small_lane_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2 == LANE_NARROW) |-> (hi_carry[NIB_SML] == sub2 && hi_carry[0] == sub2));

    // R8
    logic_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lg2 |=> !carry_out);

endmodule

// File: tb/sim_split_prefix_alu.sv
module sim_split_prefix_alu;
    localparam int NOPS = 2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op_a, op_b;
    logic        op_sub, use_logic;
    logic [1:0]  lane_mode, logic_op;
    logic [63:0] result;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] qa [NOPS];
    logic [63:0] qb [NOPS];
    logic        qsub [NOPS];
    logic        qlg [NOPS];
    logic [1:0]  qmode [NOPS];
    logic [1:0]  qlop [NOPS];

    always #2 clk = ~clk;

    split_prefix_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .lane_mode(lane_mode), .use_logic(use_logic), .logic_op(logic_op),
        .result(result), .carry_out(carry_out)
    );

    function automatic logic [64:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic sub, input logic [1:0] mode,
                                          input logic lg, input logic [1:0] lop);
        logic [63:0] r;
        logic c, bb;
        int lw;
        if (lg) begin
            case (lop)
                2'b01:   r = a | b;
                2'b10:   r = a ^ b;
                default: r = a & b;
            endcase
            return {1'b0, r};
        end
        lw = (mode == 2'b01) ? 16 : (mode == 2'b10) ? 8 : 64;
        c = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i % lw == 0) c = sub;
            bb   = sub ? ~b[i] : b[i];
            r[i] = a[i] ^ bb ^ c;
            c    = (a[i] & bb) | (a[i] & c) | (bb & c);
        end
        return {c, r};
    endfunction

    function automatic string tag_of(input int i);
        if (i == 0 || i == 7) return "R9";
        if (qlg[i])           return "R8";
        if (qmode[i] == 2'b01) return "R5";
        if (qmode[i] == 2'b10) return "R6";
        if (qmode[i] == 2'b11) return "R7";
        if (qsub[i])          return "R3";
        return "R2";
    endfunction

    task automatic set_op(input int i, input logic [63:0] a, input logic [63:0] b,
                          input logic sub, input logic [1:0] mode,
                          input logic lg, input logic [1:0] lop);
        qa[i] = a; qb[i] = b; qsub[i] = sub; qmode[i] = mode; qlg[i] = lg; qlop[i] = lop;
    endtask

    task automatic drive_idle();
        op_a = '0; op_b = '0; op_sub = 1'b0; lane_mode = 2'b00; use_logic = 1'b0; logic_op = 2'b00;
    endtask

    task automatic check_lo(input int i);
        logic [64:0] e;
        e = model(qa[i], qb[i], qsub[i], qmode[i], qlg[i], qlop[i]);
        checks++;
        if (result[31:0] !== e[31:0]) begin
            fails++;
            $display("FAIL R4+%s op %0d low half: got %h expected %h", tag_of(i), i, result[31:0], e[31:0]);
        end
    endtask

    task automatic check_hi(input int i);
        logic [64:0] e;
        e = model(qa[i], qb[i], qsub[i], qmode[i], qlg[i], qlop[i]);
        checks++;
        if (result[63:32] !== e[63:32] || carry_out !== e[64]) begin
            fails++;
            $display("FAIL R4+%s op %0d high half/carry: got %h/%b expected %h/%b",
                     tag_of(i), i, result[63:32], carry_out, e[63:32], e[64]);
        end
    endtask

    initial begin
        void'($urandom(32'h1CE5_0A11));
        // directed corners
        set_op(0, '1, 64'd1, 0, 2'b00, 0, 2'b00);                                  // R9 ripple
        set_op(1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1, 2'b00, 0, 0); // R3 equal
        set_op(2, '1, 64'h0001_0001_0001_0001, 0, 2'b01, 0, 2'b00);                // R5 lanes wrap
        set_op(3, {8{8'h80}}, {8{8'h80}}, 0, 2'b10, 0, 2'b00);                      // R6 lanes wrap
        set_op(4, '1, 64'd1, 0, 2'b11, 0, 2'b00);                                  // R7 alt full
        set_op(5, 64'hF0F0_1234_AAAA_0F0F, 64'h0FF0_4321_5555_FFFF, 1, 2'b10, 1, 2'b10); // R8 ignores sub/mode
        set_op(6, '0, 64'd1, 1, 2'b00, 0, 2'b00);                                  // R3 borrow
        set_op(7, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 2'b00, 0, 2'b00);             // R9 half crossing
        set_op(8, {4{16'h0000}}, {4{16'h0001}}, 1, 2'b01, 0, 2'b00);               // R5 sub per lane
        set_op(9, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 0, 2'b00, 1, 2'b11); // R8 op 11
        for (int i = 10; i < NOPS; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case ($urandom % 6)
                0: b = ~a;
                1: a = '1;
                2: b = a;
                default: ;
            endcase
            set_op(i, a, b, 1'($urandom), 2'($urandom), ($urandom % 4) == 0, 2'($urandom));
        end

        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: got %h/%b expected 0/0", result, carry_out);
        end
        rst_n = 1'b1;
        for (int t = 0; t < NOPS + 3; t++) begin
            @(negedge clk);
            if (t == 1) begin
                checks++;
                if (result !== '0 || carry_out !== 1'b0) begin
                    fails++;
                    $display("FAIL R1 after release: got %h/%b expected 0/0", result, carry_out);
                end
            end
            if (t >= 2 && t - 2 < NOPS) check_lo(t - 2);
            if (t >= 3 && t - 3 < NOPS) check_hi(t - 3);
            if (t < NOPS) begin
                op_a = qa[t]; op_b = qb[t]; op_sub = qsub[t]; lane_mode = qmode[t];
                use_logic = qlg[t]; logic_op = qlop[t];
            end else begin
                drive_idle();
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule